// File: doc/BRIEF.md
# Interleaved Multi-Channel Delay Merger

This block delays each trigger rising edge by a programmable number of clock cycles and emits a fixed-width output pulse. It can handle delays longer than the spacing between triggers. To do this, it deals successive trigger edges in turn to four independent delay channels. Each channel keeps its own copy of the delay value, so one channel can still be counting a long delay while newer triggers start in the other channels. The channel outputs are ORed into one output line.

Trigger edges are detected synchronously. Each detected edge makes a one-clock start strobe for the channel that the round-robin pointer selects, and the pointer then moves on. A trigger can land on a channel that is still counting or still firing. That trigger is discarded, and a sticky overrun flag is raised until the next reset. With four channels, the total delay must stay below four trigger periods.

Top module: `delay_merger`

## Requirements
- R1: While reset is asserted and after it is released, `pulseOut` and `overrun` are 0. The pointer selects channel 0.
- R2: Let the trigger rise be sampled high at a clock edge k, where it was low at edge k-1. An accepted trigger then makes `pulseOut` go high just after edge k+2+D. D is the unsigned `delayData` value sampled at edge k.
- R3: Each accepted trigger drives its channel's output high for exactly PW clock cycles (default 3).
- R4: `delayData` is captured once per trigger, at edge k. Changing it afterwards does not alter the pulse already scheduled.
- R5: Triggers spaced closer than their delay each still produce their own pulse at the time given by R2. Up to four triggers can be outstanding at once.
- R6: Triggers go to channels 0,1,2,3,0,... in arrival order. At most one channel start strobe is active in any cycle.
- R7: A trigger whose chosen channel is busy produces no pulse. A channel is busy from its start strobe until its pulse ends. Such a trigger sets `overrun` high just after edge k, and `overrun` stays high until reset. A channel never receives a start strobe while busy.
- R8: The pointer also advances on a dropped trigger, so the next trigger goes to the following channel.
- R9: `pulseOut` is the OR of all channel pulses. Overlapping pulses merge into one high stretch, and `pulseOut` is never high unless a channel is active.
- R10: Holding `trigIn` high for many cycles counts as one trigger.
- R11: A delay of 0 gives the minimum latency: `pulseOut` rises just after edge k+2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| trigIn | input | 1 | Trigger level, synchronous to clk; a rising edge requests a delayed pulse |
| delayData | input | DW (16) | Delay in clock cycles applied to the next trigger |
| pulseOut | output | 1 | Merged delayed pulse output |
| overrun | output | 1 | Sticky flag: a trigger was dropped because its channel was busy |

## Verification
The output pulse rises 2+D edges after the edge that samples the trigger rise. It stays high for PW cycles. The overrun flag rises one edge after that sampling edge.

The bench keeps its own per-cycle expected waveform. When it raises a trigger, it computes the exact cycle index of each expected high level from these latencies. It also computes each channel's busy window and the round-robin pointer, so it knows which triggers should be dropped.

The bench drives inputs and compares both outputs on every falling edge. Each comparison therefore sits half a cycle after the rising edge that produced the value.

// File: rtl/dmrg_pkg.sv
package dmrg_pkg;
  localparam int NCH  = 4;
  localparam int PTRW = (NCH > 1) ? $clog2(NCH) : 1;

  typedef struct packed {
    logic [NCH-1:0] start;
    logic           drop;
  } ctlStb_t;

  typedef enum logic [1:0] {
    CH_IDLE = 2'd0,
    CH_WAIT = 2'd1,
    CH_FIRE = 2'd2
  } chState_t;
endpackage

// File: rtl/dmrg_ctrl.sv
module dmrg_ctrl
  import dmrg_pkg::*;
(
  input  logic           clk,
  input  logic           rstN,
  input  logic           trigIn,
  input  logic [NCH-1:0] chanBusy,
  output ctlStb_t        stb,
  output logic           overrun
);
  logic            trigQ;
  logic            syncPulse;
  logic [PTRW-1:0] rrPtr;
  logic [NCH-1:0]  startQ;
  logic            dropQ;
  logic            ovrQ;
  logic [NCH-1:0]  pending;

  // edge detect on the synchronous trigger level
  assign syncPulse = trigIn & ~trigQ;
  // a channel counts as occupied from the strobe cycle onward
  assign pending   = chanBusy | startQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      trigQ  <= 1'b0;
      rrPtr  <= '0;
      startQ <= '0;
      dropQ  <= 1'b0;
      ovrQ   <= 1'b0;
    end else begin
      trigQ  <= trigIn;
      startQ <= '0;
      dropQ  <= 1'b0;
      if (syncPulse) begin
        if (pending[rrPtr]) begin
          dropQ <= 1'b1;
          ovrQ  <= 1'b1;
        end else begin
          startQ[rrPtr] <= 1'b1;
        end
        rrPtr <= (rrPtr == PTRW'(NCH - 1)) ? '0 : rrPtr + 1'b1;
      end
    end
  end

  assign stb.start = startQ;
  assign stb.drop  = dropQ;
  assign overrun   = ovrQ;
endmodule

// File: rtl/dmrg_channel.sv
module dmrg_channel
  import dmrg_pkg::*;
#(
  parameter int DW = 16,
  parameter int PW = 3
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          start,
  input  logic [DW-1:0] loadVal,
  output logic          busy,
  output logic          active
);
  localparam int PCW = (PW > 1) ? $clog2(PW) : 1;

  chState_t       state;
  logic [DW-1:0]  delayReg;
  logic [DW-1:0]  waitCnt;
  logic [PCW-1:0] fireCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= CH_IDLE;
      delayReg <= '0;
      waitCnt  <= '0;
      fireCnt  <= '0;
    end else begin
      unique case (state)
        CH_IDLE: begin
          if (start) begin
            delayReg <= loadVal;
            waitCnt  <= '0;
            state    <= CH_WAIT;
          end
        end
        CH_WAIT: begin
          if (waitCnt == delayReg) begin
            fireCnt <= '0;
            state   <= CH_FIRE;
          end else begin
            waitCnt <= waitCnt + 1'b1;
          end
        end
        CH_FIRE: begin
          if (fireCnt == PCW'(PW - 1)) begin
            state <= CH_IDLE;
          end else begin
            fireCnt <= fireCnt + 1'b1;
          end
        end
        default: state <= CH_IDLE;
      endcase
    end
  end

  assign busy   = (state != CH_IDLE);
  assign active = (state == CH_FIRE);
endmodule

// File: rtl/dmrg_datapath.sv
module dmrg_datapath
  import dmrg_pkg::*;
#(
  parameter int DW = 16,
  parameter int PW = 3
) (
  input  logic           clk,
  input  logic           rstN,
  input  ctlStb_t        stb,
  input  logic [DW-1:0]  delayData,
  output logic [NCH-1:0] chanBusy,
  output logic           pulseOut
);
  logic [DW-1:0]  dataStage;
  logic [NCH-1:0] chanActive;

  // aligns the delay value with the registered start strobe
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) dataStage <= '0;
    else       dataStage <= delayData;
  end

  for (genvar g = 0; g < NCH; g++) begin : g_chan
    dmrg_channel #(.DW(DW), .PW(PW)) u_chan (
      .clk    (clk),
      .rstN   (rstN),
      .start  (stb.start[g]),
      .loadVal(dataStage),
      .busy   (chanBusy[g]),
      .active (chanActive[g])
    );
  end

  assign pulseOut = |chanActive;
endmodule

// File: rtl/delay_merger.sv
module delay_merger
  import dmrg_pkg::*;
#(
  parameter int DW = 16,
  parameter int PW = 3
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          trigIn,
  input  logic [DW-1:0] delayData,
  output logic          pulseOut,
  output logic          overrun
);
  ctlStb_t        ctlStb;
  logic [NCH-1:0] chanBusy;

  dmrg_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .trigIn  (trigIn),
    .chanBusy(chanBusy),
    .stb     (ctlStb),
    .overrun (overrun)
  );

  dmrg_datapath #(.DW(DW), .PW(PW)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (ctlStb),
    .delayData(delayData),
    .chanBusy (chanBusy),
    .pulseOut (pulseOut)
  );
endmodule

// File: rtl/delay_merger_chk.sv
module delay_merger_chk
  import dmrg_pkg::*;
(
  input logic           clk,
  input logic           rstN,
  input logic           pulseOut,
  input logic           overrun,
  input logic [NCH-1:0] startVec,
  input logic           dropStb,
  input logic [NCH-1:0] chanBusy
);
  // R1
  p_reset_quiet_r1: assert property (@(posedge clk)
    !rstN |=> (!pulseOut && !overrun));

  // R6
  p_one_start_r6: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(startVec));

  // R7
  p_start_idle_r7: assert property (@(posedge clk) disable iff (!rstN)
    (startVec & chanBusy) == '0);

  // R7
  p_drop_flags_r7: assert property (@(posedge clk) disable iff (!rstN)
    dropStb |-> overrun);

  // R7
  p_overrun_sticky_r7: assert property (@(posedge clk) disable iff (!rstN)
    overrun |=> overrun);

  // R10
  p_strobe_single_r10: assert property (@(posedge clk) disable iff (!rstN)
    ((|startVec) || dropStb) |=> !((|startVec) || dropStb));

  // R9
  p_out_needs_chan_r9: assert property (@(posedge clk) disable iff (!rstN)
    pulseOut |-> (|chanBusy));
endmodule

bind delay_merger delay_merger_chk u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .pulseOut(pulseOut),
  .overrun (overrun),
  .startVec(ctlStb.start),
  .dropStb (ctlStb.drop),
  .chanBusy(chanBusy)
);

// File: tb/delay_merger_tb.sv
`timescale 1ns/1ps
module delay_merger_tb;
  localparam int DW    = 16;
  localparam int PW    = 3;
  localparam int NCHAN = 4;
  localparam int HORIZ = 4096;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          trigIn = 1'b0;
  logic [DW-1:0] delayData = '0;
  logic          pulseOut;
  logic          overrun;

  int nCmp = 0;
  int nBad = 0;
  int now = 0;
  int ovrFrom = 1 << 30;
  int rrModel = 0;
  int busyTill [NCHAN];
  bit expHi [HORIZ];
  string curTag = "R1";

  always #10 clk = ~clk;

  delay_merger #(.DW(DW), .PW(PW)) u_dut (
    .clk(clk), .rstN(rstN), .trigIn(trigIn), .delayData(delayData),
    .pulseOut(pulseOut), .overrun(overrun)
  );

  task automatic check(input string tag, input string what, input logic got, input logic exp);
    nCmp++;
    if (got !== exp) begin
      nBad++;
      $display("FAIL %s %s at cycle %0d: actual %b expected %b", tag, what, now, got, exp);
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  endtask

  // advance to the next falling edge and compare both outputs with the model
  task automatic step();
    @(negedge clk);
    now++;
    check(curTag, "pulseOut", pulseOut, (now < HORIZ) ? expHi[now] : 1'b0);
    check(curTag, "overrun", overrun, now >= ovrFrom);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  // raise trigger at the current falling edge; model acceptance per R2/R3/R7/R8
  task automatic fire(input int d, input int post, input int hold);
    trigIn    = 1'b1;
    delayData = DW'(d);
    if (now <= busyTill[rrModel]) begin
      if (ovrFrom > now + 1) ovrFrom = now + 1;
    end else begin
      for (int c = now + 3 + d; c <= now + 2 + d + PW; c++)
        if (c < HORIZ) expHi[c] = 1'b1;
      busyTill[rrModel] = now + 2 + d + PW;
    end
    rrModel = (rrModel + 1) % NCHAN;
    step();
    delayData = DW'(post);
    for (int i = 1; i < hold; i++) step();
    trigIn = 1'b0;
  endtask

  task automatic do_reset();
    trigIn = 1'b0;
    delayData = '0;
    @(negedge clk);
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    now = 0;
    ovrFrom = 1 << 30;
    rrModel = 0;
    foreach (busyTill[i]) busyTill[i] = -100;
    foreach (expHi[i]) expHi[i] = 1'b0;
    rstN = 1'b1;
    check("R1", "pulseOut after reset", pulseOut, 1'b0);
    check("R1", "overrun after reset", overrun, 1'b0);
  endtask

  task automatic t_reset();
    curTag = "R1";
    do_reset();
    idle(4);
  endtask

  task automatic t_single();
    curTag = "R2/R3";
    do_reset();
    fire(5, 5, 1);
    idle(15);
  endtask

  task automatic t_zero();
    curTag = "R11";
    do_reset();
    fire(0, 0, 1);
    idle(8);
  endtask

  task automatic t_capture();
    curTag = "R4";
    do_reset();
    fire(4, 20, 1);
    idle(30);
  endtask

  task automatic t_long();
    curTag = "R5/R6/R9";
    do_reset();
    fire(30, 30, 1); idle(5);
    fire(25, 25, 1); idle(5);
    fire(20, 20, 1); idle(5);
    fire(15, 15, 1);
    idle(30);
  endtask

  task automatic t_overrun();
    curTag = "R7/R8";
    do_reset();
    fire(40, 40, 1); idle(3);
    fire(0, 0, 1);   idle(3);
    fire(40, 40, 1); idle(3);
    fire(40, 40, 1); idle(3);
    fire(40, 40, 1); idle(3);
    fire(1, 1, 1);
    idle(45);
  endtask

  task automatic t_hold();
    curTag = "R10";
    do_reset();
    fire(2, 2, 8);
    idle(10);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nBad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    t_reset();
    t_single();
    t_zero();
    t_capture();
    t_long();
    t_overrun();
    t_hold();
    finish_run();
  end
endmodule